// File: doc/BRIEF.md
# Prescaled Backlight PWM Generator

This block produces one pulse-width-modulated level for panel backlight dimming. Its clock is the reference clock. A plain register-write port (address, byte of data, write strobe) programs four settings: an 8-bit prescale divider, a 16-bit step count, a 16-bit duty value, and a control byte with an enable bit and a polarity bit. One PWM period is made of step-count steps, each lasting prescale reference clocks, followed by one extra reference clock.

The PWM level reaches the outside through a small pin function mux. The mux gives 2 bits to each of four general-purpose pins. Only the top pin can carry the PWM. Every pin that is not selected for the PWM drives the value on its GPIO input.

Timing writes go into shadow copies. The counters pick them up only when a period ends, or at any time while the generator is disabled. This keeps a waveform from ever mixing old and new settings.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset every register reads as zero, the generator is disabled, and every pin drives its GPIO input value.
- R2: While enabled, one PWM period lasts exactly P*S+1 reference clocks, where P is the effective prescale and S is the step count.
- R3: With duty D < S, the active level is held for the first D*P clocks of each period and the inactive level for the rest.
- R4: A duty D >= S, including D = S, holds the active level for the whole period (full on).
- R5: A prescale value of 0 behaves exactly like a prescale value of 1.
- R6: Register map, written one byte at a time. Prescale is at 0xA0. The step count is at 0xA1 (low byte) and 0xA2 (high byte). Duty is at 0xA3 (low byte) and 0xA4 (high byte). Control is at 0xA5.
- R7: Control bit 1 enables the generator and bit 0 inverts it. The active level is high, or low when inverted. While disabled, the PWM stays at the inactive level: low, or high when inverted.
- R8: A new prescale, step count or duty value takes effect only at the start of the next period. The period in progress finishes with the old values.
- R9: While disabled, the counters are held at zero, so enabling the generator starts a fresh period at its first clock.
- R10: The pin mux register is at 0x10, with pin i at bits 2i+1:2i. Pin 3 (bits 7:6) shows the PWM only when its code is 2'b10. Any other code on pin 3, and every code on pins 0 to 2, makes the pin drive its GPIO input.
- R11: A write to any other address changes no setting and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| gpio_val | input | 4 | Per-pin value used when the pin is not muxed to the PWM |
| pin_out | output | 4 | Pin levels after the function mux |

## Verification
The settings are varied so that each one shows its own effect. With prescale 3, step count 5 and duty 2, a wrong P*S+1 period length shows up, and so does a missing final clock. Duty values equal to and above the step count separate clamping from wrap-around. A zero prescale tells the substitute-one rule apart from a stalled counter.

Writes made in the middle of a period show whether shadow loading waits for the period boundary. Toggling enable shows whether the counters restart. Cycling through the mux codes while the GPIO inputs change shows which source each pin drives. A 16-bit step count makes sure the high byte is placed in the upper half of the register.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int PRE_W = 8;
  localparam int CNT_W = 16;

  localparam logic [7:0] ADDR_PRE      = 8'hA0;
  localparam logic [7:0] ADDR_SCALE_LO = 8'hA1;
  localparam logic [7:0] ADDR_SCALE_HI = 8'hA2;
  localparam logic [7:0] ADDR_DUTY_LO  = 8'hA3;
  localparam logic [7:0] ADDR_DUTY_HI  = 8'hA4;
  localparam logic [7:0] ADDR_CTRL     = 8'hA5;
  localparam logic [7:0] ADDR_MUX      = 8'h10;

  localparam int CTRL_EN_BIT  = 1;
  localparam int CTRL_INV_BIT = 0;

  localparam logic [1:0] MUX_SPECIAL = 2'b10;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] scale;
    logic [CNT_W-1:0] duty;
  } bl_timing_t;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [7:0]         addr,
  input  logic [7:0]         wdata,
  output bl_timing_t         shadow,
  output logic               en,
  output logic               inv,
  output logic [2*NPINS-1:0] mux
);
  localparam int MUX_W = 2 * NPINS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      en     <= 1'b0;
      inv    <= 1'b0;
      mux    <= '0;
    end else if (we) begin
      case (addr)
        ADDR_PRE:      shadow.pre         <= wdata[PRE_W-1:0];
        ADDR_SCALE_LO: shadow.scale[7:0]  <= wdata;
        ADDR_SCALE_HI: shadow.scale[15:8] <= wdata;
        ADDR_DUTY_LO:  shadow.duty[7:0]   <= wdata;
        ADDR_DUTY_HI:  shadow.duty[15:8]  <= wdata;
        ADDR_CTRL: begin
          en  <= wdata[CTRL_EN_BIT];
          inv <= wdata[CTRL_INV_BIT];
        end
        ADDR_MUX:      mux <= wdata[MUX_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             inv,
  input  bl_timing_t       shadow,
  output bl_timing_t       act,
  output logic [CNT_W-1:0] step,
  output logic [PRE_W-1:0] phase,
  output logic             period_end,
  output logic             pwm
);
  logic [PRE_W-1:0] pre_eff;
  logic             last_phase;
  logic             high;

  always_comb begin
    pre_eff    = (act.pre == '0) ? PRE_W'(1) : act.pre;
    last_phase = (phase == pre_eff - PRE_W'(1));
    period_end = (step == act.scale);
    high       = (act.duty >= act.scale) || (step < act.duty);
    pwm        = en ? (high ^ inv) : inv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= '0;
      step  <= '0;
      phase <= '0;
    end else if (!en || period_end) begin
      act   <= shadow;
      step  <= '0;
      phase <= '0;
    end else if (last_phase) begin
      phase <= '0;
      step  <= step + CNT_W'(1);
    end else begin
      phase <= phase + PRE_W'(1);
    end
  end
endmodule

// File: rtl/bl_pwm_pinmux.sv
module bl_pwm_pinmux
  import bl_pwm_pkg::*;
#(
  parameter int NPINS   = 4,
  parameter int PWM_PIN = 3
) (
  input  logic [2*NPINS-1:0] mux,
  input  logic               pwm,
  input  logic [NPINS-1:0]   gpio_val,
  output logic [NPINS-1:0]   pins
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    if (i == PWM_PIN) begin : g_pwm
      assign pins[i] = (mux[2*i+1:2*i] == MUX_SPECIAL) ? pwm : gpio_val[i];
    end else begin : g_gpio
      assign pins[i] = gpio_val[i];
    end
  end
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
#(
  parameter int NPINS   = 4,
  parameter int PWM_PIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [7:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  input  logic [NPINS-1:0] gpio_val,
  output logic [NPINS-1:0] pin_out
);
  localparam int MUX_W = 2 * NPINS;

  bl_timing_t       shadow;
  bl_timing_t       act;
  logic             ctrl_en;
  logic             ctrl_inv;
  logic [MUX_W-1:0] mux_sel;
  logic [CNT_W-1:0] step;
  logic [PRE_W-1:0] phase;
  logic             period_end;
  logic             pwm;

  bl_pwm_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .shadow(shadow), .en(ctrl_en), .inv(ctrl_inv), .mux(mux_sel)
  );

  bl_pwm_core u_core (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .inv(ctrl_inv), .shadow(shadow),
    .act(act), .step(step), .phase(phase), .period_end(period_end), .pwm(pwm)
  );

  bl_pwm_pinmux #(.NPINS(NPINS), .PWM_PIN(PWM_PIN)) u_mux (
    .mux(mux_sel), .pwm(pwm), .gpio_val(gpio_val), .pins(pin_out)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk
  import bl_pwm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             inv,
  input logic [CNT_W-1:0] step,
  input logic [PRE_W-1:0] phase,
  input logic [CNT_W-1:0] scale_a,
  input logic [PRE_W-1:0] pre_a,
  input logic             period_end,
  input logic             pwm
);
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step <= scale_a);

  // R5
  zero_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_a == '0) |-> (phase == '0));

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !period_end) |=> ($stable(scale_a) && $stable(pre_a)));

  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (step == '0 && phase == '0));

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pwm == inv));
endmodule

bind bl_pwm_top bl_pwm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_en), .inv(ctrl_inv), .step(step),
  .phase(phase), .scale_a(act.scale), .pre_a(act.pre),
  .period_end(period_end), .pwm(pwm)
);

// File: tb/tb_bl_pwm_top.sv
module tb_bl_pwm_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [3:0] gpio_val = 4'b1010;
  logic [3:0] pin_out;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";

  bl_pwm_top dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .gpio_val(gpio_val), .pin_out(pin_out)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int m_pre, m_scale, m_duty, a_pre, a_scale, a_duty, t;
  bit m_en, m_inv;
  logic [7:0] m_mux;

  function automatic bit model_pwm();
    int pe, s;
    bit high;
    pe   = (a_pre == 0) ? 1 : a_pre;
    s    = (t < pe * a_scale) ? t / pe : a_scale;
    high = (a_duty >= a_scale) || (s < a_duty);
    return m_en ? (high ^ m_inv) : m_inv;
  endfunction

  function automatic logic [3:0] model_pins();
    logic [3:0] p;
    p = gpio_val;
    if (m_mux[7:6] == 2'b10) p[3] = model_pwm();
    return p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_scale = 0; m_duty = 0; a_pre = 0; a_scale = 0; a_duty = 0;
      t = 0; m_en = 0; m_inv = 0; m_mux = '0;
    end else begin
      int pe, len;
      pe  = (a_pre == 0) ? 1 : a_pre;
      len = pe * a_scale + 1;
      if (!m_en || t == len - 1) begin
        t = 0; a_pre = m_pre; a_scale = m_scale; a_duty = m_duty;
      end else begin
        t = t + 1;
      end
      if (reg_we) begin
        case (reg_addr)
          8'hA0: m_pre = reg_wdata;
          8'hA1: m_scale = (m_scale & 32'hFF00) | reg_wdata;
          8'hA2: m_scale = (m_scale & 32'h00FF) | (int'(reg_wdata) << 8);
          8'hA3: m_duty = (m_duty & 32'hFF00) | reg_wdata;
          8'hA4: m_duty = (m_duty & 32'h00FF) | (int'(reg_wdata) << 8);
          8'hA5: begin m_en = reg_wdata[1]; m_inv = reg_wdata[0]; end
          8'h10: m_mux = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input logic [3:0] got, input logic [3:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: pin_out=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // every-cycle comparison, sampled away from the clock edge
  always @(posedge clk) begin
    #5;
    if (rst_n) check(pin_out, model_pins(), cur_req);
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_high(input int n, input int exp, input string req);
    int c;
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
      if (pin_out[3]) c++;
    end
    checks++;
    if (c != exp) begin
      errors++;
      $display("FAIL %s: high clocks=%0d expected %0d", req, c, exp);
    end
  endtask

  initial begin
    repeat (1_000) @(posedge clk);
    // watchdog covers the whole run length below
  end

  initial begin : watchdog
    repeat (20_000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1: reset state, pins follow GPIO inputs
    cur_req = "R1";
    idle(4);
    gpio_val = 4'b0101;
    idle(4);

    // R6 / R10: program map and route the PWM to pin 3
    cur_req = "R6";
    wr(8'h10, 8'h80);
    wr(8'hA0, 8'd3); wr(8'hA1, 8'd5); wr(8'hA2, 8'd0);
    wr(8'hA3, 8'd2); wr(8'hA4, 8'd0);
    wr(8'hA5, 8'h02);
    // R2 / R3: period 16 clocks, 6 high
    cur_req = "R3";
    idle(40);
    count_high(16, 6, "R3");
    count_high(32, 12, "R2");

    // R7: inverted polarity
    cur_req = "R7";
    wr(8'hA5, 8'h03);
    idle(40);
    count_high(16, 10, "R7");

    // R4: duty above step count clamps to full on
    cur_req = "R4";
    wr(8'hA3, 8'd7);
    wr(8'hA5, 8'h02);
    idle(40);
    count_high(32, 32, "R4");
    wr(8'hA3, 8'd5);
    idle(40);
    count_high(16, 16, "R4");

    // R5: zero prescale acts as one -> 6-clock period, 2 high
    cur_req = "R5";
    wr(8'hA0, 8'd0); wr(8'hA3, 8'd2);
    idle(30);
    count_high(6, 2, "R5");

    // R8: change mid-period, model tracks boundary loading
    cur_req = "R8";
    idle(2);
    wr(8'hA1, 8'd9);
    idle(8);
    wr(8'hA0, 8'd2);
    idle(40);

    // R9 / R7: disable gives inactive level, enable restarts
    cur_req = "R9";
    wr(8'hA5, 8'h00);
    idle(3);
    count_high(5, 0, "R7");
    wr(8'hA5, 8'h01);
    idle(2);
    count_high(5, 5, "R7");
    wr(8'hA5, 8'h02);
    idle(40);

    // R6: 16-bit step count via high byte: P=1, S=256, D=128
    cur_req = "R6";
    wr(8'hA0, 8'd1);
    wr(8'hA1, 8'h00); wr(8'hA2, 8'h01);
    wr(8'hA3, 8'h80); wr(8'hA4, 8'h00);
    idle(600);
    count_high(257, 128, "R6");

    // R11: unmapped addresses are ignored
    cur_req = "R11";
    wr(8'hA6, 8'hFF); wr(8'h9F, 8'hFF); wr(8'h11, 8'h00); wr(8'h0F, 8'h00);
    idle(300);
    count_high(257, 128, "R11");

    // R10: other mux codes route GPIO; low pins always GPIO
    cur_req = "R10";
    wr(8'h10, 8'h40);
    gpio_val = 4'b1000; idle(5);
    gpio_val = 4'b0111; idle(5);
    wr(8'h10, 8'hFF);
    gpio_val = 4'b1001; idle(5);
    wr(8'h10, 8'hBF);
    gpio_val = 4'b0110; idle(20);
    @(posedge clk); #5;
    check({1'b0, pin_out[2:0]}, {1'b0, gpio_val[2:0]}, "R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule